// File: doc/BRIEF.md
# Synchronous Serial Absolute Encoder Frame Receiver

This block is the master end of a synchronous serial link to an absolute position encoder. On a request it sends a burst of clock pulses on a line that otherwise rests high. It reads the encoder's serial data line once per pulse, most significant bit first, and assembles a frame whose length is set at build time. The last bit of the frame is a parity bit. The block checks that bit and then removes it. The data bits that remain are published in two ways: as a zero-extended 32-bit monitor word, and split into a multi-turn field, a single-turn field and a status field.

The block can also look for wiring faults on the data line. It tells a reversed data wire apart from a general data-signal fault and reports each with its own 12-bit code. A parity mismatch also counts as an error and has a third code. A downstream position counter receives an update strobe only for frames that finish with no fault of any kind. Each request ends with exactly one single-cycle result strobe. That strobe carries the error flag and the error code.

Top module: `ssi_frame_rx`

## Requirements
- R1: While idle, `ssi_clk` is high. A `start` pulse in idle produces FRAME_LEN+1 low pulses on `ssi_clk`, each low for HALF_CYC cycles of `clk` and each followed by HALF_CYC high cycles. A `start` pulse while a frame is in progress is ignored and causes no extra pulses and no extra result.
- R2: The first rising edge of `ssi_clk` is the acknowledge slot. The line is sampled at the next FRAME_LEN rising edges, and the first bit sampled is the most significant bit of the frame.
- R3: Every frame that is clocked out loads `rx_mon` with the FRAME_LEN-1 data bits. The frame's last bit is the parity bit and is excluded. The data bits sit right-aligned in bit 0 upward, and every bit above them is 0. `rx_mon` changes only on a `valid` cycle.
- R4: The data bits are split from the most significant end downward: MT_W bits of `multi_turn`, then ST_W bits of `single_turn`, then SS_W bits of `status` in the least significant bits.
- R5: Parity is even when `odd_par`=0: the XOR of all data bits and the parity bit must be 0. It is odd when `odd_par`=1: that XOR must be 1. A mismatch sets `error` with `err_code`=0x10B.
- R6: If `det_en`=1 and the data line is low when `start` arrives in idle, no clock pulse is sent. `valid` is then raised with `error`=1 and `err_code`=0x109, and `rx_mon` and the fields keep their values.
- R7: If `det_en`=1, a data-signal fault is reported as `err_code`=0x10A. This happens when the line is still high at the acknowledge slot, or when the line is not high again MONO_CYC cycles after the last rising edge. This code takes precedence over a parity mismatch.
- R8: With `det_en`=0, codes 0x109 and 0x10A are never reported. The frame is clocked and checked for parity as usual.
- R9: `pos_upd` pulses together with `valid` only when `error`=0. `multi_turn`, `single_turn` and `status` change only on such a cycle.
- R10: Each accepted `start` gives exactly one single-cycle `valid` pulse. When `error`=0, `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one frame (taken only in idle) |
| det_en | input | 1 | Enable wiring-fault detection |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even |
| ssi_clk | output | 1 | Clock to the encoder, rests high |
| ssi_data | input | 1 | Serial data from the encoder |
| valid | output | 1 | One-cycle result strobe |
| error | output | 1 | Frame ended with a fault |
| err_code | output | 12 | 0, 0x109 reversed wire, 0x10A signal fault, 0x10B parity |
| multi_turn | output | MT_W | Multi-turn position field |
| single_turn | output | ST_W | Single-turn position field |
| status | output | SS_W | Encoder status field |
| rx_mon | output | MON_W | Right-aligned data bits without parity |
| pos_upd | output | 1 | Update strobe for the position counter |

## Verification
A wrong bit count or a slip in the pulse sequencer shows on `ssi_clk` while the frame is still running. It also corrupts `rx_mon` by one bit position at the `valid` strobe, about 270 cycles after `start`. A lost or wrongly latched fault flag shows at the same strobe as a wrong `err_code` or a stray `pos_upd`. A field that updates when it should hold shows on an error frame, because the bench compares those fields against the last good frame. The bench also drives an encoder model that does not acknowledge, holds the line low, or rests low, so that each fault path produces its own code.

// File: rtl/ssi_rx_pkg.sv
package ssi_rx_pkg;

   localparam logic [11:0] CODE_NONE     = 12'h000;
   localparam logic [11:0] CODE_REVERSED = 12'h109;
   localparam logic [11:0] CODE_SIGNAL   = 12'h10A;
   localparam logic [11:0] CODE_PARITY   = 12'h10B;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_MONO,
      ST_DONE
   } seq_state_t;

   typedef struct packed {
      logic rev;
      logic sig;
   } line_fault_t;

endpackage

// File: rtl/ssi_rx_sync.sv
module ssi_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-1:0] << 1} | {{(STAGES-1){1'b0}}, d_in};
         end
         assign d_out = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ssi_rx_seq.sv
module ssi_rx_seq
   import ssi_rx_pkg::*;
#(
   parameter int FRAME_LEN = 29,
   parameter int HALF_CYC  = 4,
   parameter int MONO_CYC  = 20
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        det_en,
   input  logic        data_s,
   output logic        ssi_clk,
   output logic        frame_clr,
   output logic        smp_en,
   output logic        done,
   output line_fault_t fault
);

   localparam int HW = $clog2(HALF_CYC + 1);
   localparam int BW = $clog2(FRAME_LEN + 2);
   localparam int MW = $clog2(MONO_CYC + 1);

   seq_state_t      state;
   logic [HW-1:0]   half_cnt;
   logic [BW-1:0]   bit_idx;
   logic [MW-1:0]   mono_cnt;
   logic            half_last;
   logic            mono_last;
   logic            rev_now;

   assign half_last = (half_cnt == HW'(HALF_CYC - 1));
   assign mono_last = (mono_cnt == MW'(MONO_CYC - 1));
   assign rev_now   = det_en && !data_s;

   assign frame_clr = (state == ST_IDLE) && start && !rev_now;
   assign smp_en    = (state == ST_LOW) && half_last && (bit_idx != '0);
   assign done      = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ssi_clk  <= 1'b1;
         half_cnt <= '0;
         bit_idx  <= '0;
         mono_cnt <= '0;
         fault    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  if (rev_now) begin
                     fault.rev <= 1'b1;
                     fault.sig <= 1'b0;
                     state     <= ST_DONE;
                  end else begin
                     fault    <= '0;
                     ssi_clk  <= 1'b0;
                     half_cnt <= '0;
                     bit_idx  <= '0;
                     state    <= ST_LOW;
                  end
               end
            end
            ST_LOW: begin
               if (half_last) begin
                  ssi_clk  <= 1'b1;
                  half_cnt <= '0;
                  if ((bit_idx == '0) && det_en && data_s) fault.sig <= 1'b1;
                  if (bit_idx == BW'(FRAME_LEN)) begin
                     mono_cnt <= '0;
                     state    <= ST_MONO;
                  end else begin
                     state <= ST_HIGH;
                  end
                  bit_idx <= bit_idx + 1'b1;
               end else begin
                  half_cnt <= half_cnt + 1'b1;
               end
            end
            ST_HIGH: begin
               if (half_last) begin
                  ssi_clk  <= 1'b0;
                  half_cnt <= '0;
                  state    <= ST_LOW;
               end else begin
                  half_cnt <= half_cnt + 1'b1;
               end
            end
            ST_MONO: begin
               if (mono_last) begin
                  if (det_en && !data_s) fault.sig <= 1'b1;
                  state <= ST_DONE;
               end else begin
                  mono_cnt <= mono_cnt + 1'b1;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ssi_rx_shift.sv
module ssi_rx_shift #(
   parameter int FRAME_LEN = 29
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 smp_en,
   input  logic                 bit_in,
   output logic [FRAME_LEN-1:0] word
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word <= '0;
      else if (clr)    word <= '0;
      else if (smp_en) word <= {word[FRAME_LEN-2:0], bit_in};
   end

endmodule

// File: rtl/ssi_rx_unpack.sv
module ssi_rx_unpack
   import ssi_rx_pkg::*;
#(
   parameter int MT_W         = 14,
   parameter int ST_W         = 13,
   parameter int SS_W         = 1,
   parameter int FRAME_LEN    = 29,
   parameter int MON_W        = 32,
   parameter bit CHECK_PARITY = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done,
   input  line_fault_t          fault,
   input  logic                 odd_par,
   input  logic [FRAME_LEN-1:0] word,
   output logic                 valid,
   output logic                 error,
   output logic [11:0]          err_code,
   output logic [MT_W-1:0]      multi_turn,
   output logic [ST_W-1:0]      single_turn,
   output logic [SS_W-1:0]      status,
   output logic [MON_W-1:0]     rx_mon,
   output logic                 pos_upd
);

   localparam int DW = FRAME_LEN - 1;

   logic [DW-1:0]    data;
   logic [MON_W-1:0] mon_next;
   logic             par_bad;
   logic [11:0]      code_next;

   assign data = word[FRAME_LEN-1:1];

   generate
      if (MON_W > DW) begin : g_mon_pad
         assign mon_next = {{(MON_W - DW){1'b0}}, data};
      end else begin : g_mon_full
         assign mon_next = data;
      end
      if (CHECK_PARITY) begin : g_par_on
         assign par_bad = (^word) ^ odd_par;
      end else begin : g_par_off
         assign par_bad = 1'b0;
      end
   endgenerate

   always_comb begin
      if (fault.rev)      code_next = CODE_REVERSED;
      else if (fault.sig) code_next = CODE_SIGNAL;
      else if (par_bad)   code_next = CODE_PARITY;
      else                code_next = CODE_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid       <= 1'b0;
         error       <= 1'b0;
         err_code    <= CODE_NONE;
         multi_turn  <= '0;
         single_turn <= '0;
         status      <= '0;
         rx_mon      <= '0;
         pos_upd     <= 1'b0;
      end else begin
         valid   <= done;
         pos_upd <= 1'b0;
         if (done) begin
            err_code <= code_next;
            error    <= (code_next != CODE_NONE);
            if (!fault.rev) rx_mon <= mon_next;
            if (code_next == CODE_NONE) begin
               multi_turn  <= data[DW-1 -: MT_W];
               single_turn <= data[SS_W +: ST_W];
               status      <= data[0 +: SS_W];
               pos_upd     <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ssi_frame_rx.sv
module ssi_frame_rx
   import ssi_rx_pkg::*;
#(
   parameter int MT_W         = 14,
   parameter int ST_W         = 13,
   parameter int SS_W         = 1,
   parameter int FRAME_LEN    = 29,
   parameter int MON_W        = 32,
   parameter int HALF_CYC     = 4,
   parameter int MONO_CYC     = 20,
   parameter int SYNC_STAGES  = 2,
   parameter bit CHECK_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              det_en,
   input  logic              odd_par,
   output logic              ssi_clk,
   input  logic              ssi_data,
   output logic              valid,
   output logic              error,
   output logic [11:0]       err_code,
   output logic [MT_W-1:0]   multi_turn,
   output logic [ST_W-1:0]   single_turn,
   output logic [SS_W-1:0]   status,
   output logic [MON_W-1:0]  rx_mon,
   output logic              pos_upd
);

   generate
      if (MT_W + ST_W + SS_W + 1 != FRAME_LEN) begin : g_bad_len
         $error("field widths plus parity must equal FRAME_LEN");
      end
      if (FRAME_LEN - 1 > MON_W) begin : g_bad_mon
         $error("data bits do not fit the monitor word");
      end
      if (SS_W < 1 || MT_W < 1 || ST_W < 1) begin : g_bad_field
         $error("every field needs at least one bit");
      end
      if (HALF_CYC <= SYNC_STAGES) begin : g_bad_half
         $error("half period must exceed synchroniser depth");
      end
      if (MONO_CYC <= SYNC_STAGES) begin : g_bad_mono
         $error("monoflop window must exceed synchroniser depth");
      end
   endgenerate

   logic                 data_s;
   logic                 frame_clr;
   logic                 smp_en;
   logic                 done;
   line_fault_t          fault;
   logic [FRAME_LEN-1:0] word;

   ssi_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (ssi_data),
      .d_out (data_s)
   );

   ssi_rx_seq #(
      .FRAME_LEN (FRAME_LEN),
      .HALF_CYC  (HALF_CYC),
      .MONO_CYC  (MONO_CYC)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .det_en    (det_en),
      .data_s    (data_s),
      .ssi_clk   (ssi_clk),
      .frame_clr (frame_clr),
      .smp_en    (smp_en),
      .done      (done),
      .fault     (fault)
   );

   ssi_rx_shift #(.FRAME_LEN(FRAME_LEN)) i_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (frame_clr),
      .smp_en (smp_en),
      .bit_in (data_s),
      .word   (word)
   );

   ssi_rx_unpack #(
      .MT_W         (MT_W),
      .ST_W         (ST_W),
      .SS_W         (SS_W),
      .FRAME_LEN    (FRAME_LEN),
      .MON_W        (MON_W),
      .CHECK_PARITY (CHECK_PARITY)
   ) i_unpack (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (done),
      .fault       (fault),
      .odd_par     (odd_par),
      .word        (word),
      .valid       (valid),
      .error       (error),
      .err_code    (err_code),
      .multi_turn  (multi_turn),
      .single_turn (single_turn),
      .status      (status),
      .rx_mon      (rx_mon),
      .pos_upd     (pos_upd)
   );

endmodule

// File: rtl/ssi_rx_chk.sv
module ssi_rx_chk #(
   parameter int MT_W  = 14,
   parameter int ST_W  = 13,
   parameter int SS_W  = 1,
   parameter int MON_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             det_en,
   input logic             ssi_clk,
   input logic             valid,
   input logic             error,
   input logic [11:0]      err_code,
   input logic [MT_W-1:0]  multi_turn,
   input logic [ST_W-1:0]  single_turn,
   input logic [SS_W-1:0]  status,
   input logic [MON_W-1:0] rx_mon,
   input logic             pos_upd
);

   AST_CLK_HIGH_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ssi_clk); // R1

   AST_MON_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> $stable(rx_mon)); // R3

   AST_MON_KEPT_ON_REVERSED: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && err_code == 12'h109) |-> $stable(rx_mon)); // R6

   AST_NO_LINE_CODE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !det_en) |-> (err_code != 12'h109 && err_code != 12'h10A)); // R8

   AST_UPD_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      pos_upd |-> (valid && !error)); // R9

   AST_FIELDS_HOLD_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && error) |-> ($stable(multi_turn) && $stable(single_turn) && $stable(status))); // R9

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R10

   AST_CLEAN_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !error) |-> (err_code == 12'h000)); // R10

endmodule

bind ssi_frame_rx ssi_rx_chk #(
   .MT_W  (MT_W),
   .ST_W  (ST_W),
   .SS_W  (SS_W),
   .MON_W (MON_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .det_en      (det_en),
   .ssi_clk     (ssi_clk),
   .valid       (valid),
   .error       (error),
   .err_code    (err_code),
   .multi_turn  (multi_turn),
   .single_turn (single_turn),
   .status      (status),
   .rx_mon      (rx_mon),
   .pos_upd     (pos_upd)
);

// File: tb/test_ssi_frame_rx.sv
`timescale 1ns/1ps
module test_ssi_frame_rx;

   localparam int MT_W = 14;
   localparam int ST_W = 13;
   localparam int SS_W = 1;
   localparam int FL   = 29;
   localparam int DW   = FL - 1;
   localparam int HALF = 4;
   localparam int M_OK = 0, M_NOACK = 1, M_STUCK = 2, M_REV = 3;

   typedef struct packed {
      logic [31:0]     mon;
      logic [MT_W-1:0] mt;
      logic [ST_W-1:0] st;
      logic [SS_W-1:0] ss;
      logic            err;
      logic [11:0]     code;
      logic            upd;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic det_en = 1'b1;
   logic odd_par = 1'b0;
   logic enc_data = 1'b1;
   logic ssi_clk, valid, error, pos_upd;
   logic [11:0] err_code;
   logic [MT_W-1:0] multi_turn;
   logic [ST_W-1:0] single_turn;
   logic [SS_W-1:0] status;
   logic [31:0] rx_mon;

   int n_chk = 0;
   int n_err = 0;
   int n_seen = 0;
   int fall_cnt = 0;
   int rise_cnt = 0;
   bit width_bad = 0;
   int mode = M_OK;
   logic [FL-1:0] enc_word = '0;
   realtime t_fall = 0.0;
   exp_t q[$];
   string tq[$];
   exp_t last_good = '0;

   always #2.5 clk = ~clk;

   ssi_frame_rx i_ssi_frame_rx (
      .clk(clk), .rst_n(rst_n), .start(start), .det_en(det_en), .odd_par(odd_par),
      .ssi_clk(ssi_clk), .ssi_data(enc_data), .valid(valid), .error(error),
      .err_code(err_code), .multi_turn(multi_turn), .single_turn(single_turn),
      .status(status), .rx_mon(rx_mon), .pos_upd(pos_upd)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // encoder model: changes data after each falling edge of the line clock
   always @(negedge ssi_clk) begin
      fall_cnt++;
      t_fall = $realtime;
      #1;
      if (fall_cnt == 1) enc_data = (mode == M_NOACK);
      else if (fall_cnt <= FL + 1) enc_data = enc_word[FL + 1 - fall_cnt];
   end

   always @(posedge ssi_clk) begin
      if (fall_cnt > 0) begin
         rise_cnt++;
         if (($realtime - t_fall) > (HALF * 5.0 + 0.5) || ($realtime - t_fall) < (HALF * 5.0 - 0.5))
            width_bad = 1;
         if (rise_cnt == FL + 1) begin
            #10;
            enc_data = (mode == M_STUCK) ? 1'b0 : 1'b1;
         end
      end
   end

   // monitor: compares each result against the scoreboard
   always @(negedge clk) begin
      if (rst_n && valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R10", "unexpected valid", 32'(valid), 32'h0);
         end else begin
            exp_t e;
            string t;
            e = q.pop_front();
            t = tq.pop_front();
            chk(rx_mon == e.mon, "R3", {t, " rx_mon"}, rx_mon, e.mon);
            chk(multi_turn == e.mt, "R4", {t, " multi_turn"}, 32'(multi_turn), 32'(e.mt));
            chk(single_turn == e.st, "R4", {t, " single_turn"}, 32'(single_turn), 32'(e.st));
            chk(status == e.ss, "R4", {t, " status"}, 32'(status), 32'(e.ss));
            chk(error == e.err, t, "error", 32'(error), 32'(e.err));
            chk(err_code == e.code, t, "err_code", 32'(err_code), 32'(e.code));
            chk(pos_upd == e.upd, "R9", {t, " pos_upd"}, 32'(pos_upd), 32'(e.upd));
         end
         n_seen++;
      end
   end

   task automatic run_frame(input logic [DW-1:0] d, input bit flip_par, input int md,
                            input bit det, input bit odd, input bit dbl, input string tag);
      exp_t e;
      logic par;
      bit sig, rev;
      int seen0;
      par = (^d) ^ odd;
      if (flip_par) par = ~par;
      rev = det && (md == M_REV);
      sig = det && (md == M_NOACK || md == M_STUCK);
      e = last_good;
      e.upd = 1'b0;
      if (rev) begin
         e.err = 1'b1; e.code = 12'h109;
      end else begin
         e.mon = 32'(d);
         if (sig)           begin e.err = 1'b1; e.code = 12'h10A; end
         else if (flip_par) begin e.err = 1'b1; e.code = 12'h10B; end
         else begin
            e.err = 1'b0; e.code = 12'h000; e.upd = 1'b1;
            e.mt = d[DW-1 -: MT_W]; e.st = d[SS_W +: ST_W]; e.ss = d[0 +: SS_W];
         end
      end
      last_good.mon = e.mon;
      if (!e.err) begin
         last_good.mt = e.mt; last_good.st = e.st; last_good.ss = e.ss;
      end
      q.push_back(e);
      tq.push_back(tag);
      @(negedge clk);
      det_en = det; odd_par = odd; mode = md;
      enc_word = {d, par};
      if (md == M_REV) enc_data = 1'b0;
      repeat (5) @(negedge clk);
      fall_cnt = 0; rise_cnt = 0; width_bad = 0;
      seen0 = n_seen;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (dbl) begin
         repeat (40) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (n_seen == seen0) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(fall_cnt == (rev ? 0 : FL + 1), "R1", {tag, " pulse count"}, 32'(fall_cnt),
          32'(rev ? 0 : FL + 1));
      chk(width_bad == 0, "R1", {tag, " low width"}, 32'(width_bad), 32'h0);
      chk(n_seen == seen0 + 1, "R10", {tag, " result count"}, 32'(n_seen), 32'(seen0 + 1));
      chk(ssi_clk == 1'b1, "R1", {tag, " idle clock"}, 32'(ssi_clk), 32'h1);
      mode = M_OK;
      enc_data = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(ssi_clk == 1'b1, "R1", "reset ssi_clk", 32'(ssi_clk), 32'h1);
      chk(valid == 1'b0, "R10", "reset valid", 32'(valid), 32'h0);
      chk(rx_mon == 32'h0, "R3", "reset rx_mon", rx_mon, 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(pos_upd == 1'b0, "R9", "idle pos_upd", 32'(pos_upd), 32'h0);
      chk(err_code == 12'h0, "R10", "idle err_code", 32'(err_code), 32'h0);

      run_frame(28'hA5C3F1E, 0, M_OK,    1, 0, 0, "R2 even");
      run_frame(28'hFFFFFFF, 0, M_OK,    1, 0, 0, "R2 ones");
      run_frame(28'h0000001, 0, M_OK,    1, 1, 0, "R5 odd");
      run_frame(28'h5A5A5A5, 1, M_OK,    1, 0, 0, "R5 bad parity");
      run_frame(28'h1357ACE, 0, M_NOACK, 1, 0, 0, "R7 no ack");
      run_frame(28'h2468BDF, 0, M_STUCK, 1, 0, 0, "R7 stuck low");
      run_frame(28'h0F0F0F0, 0, M_REV,   1, 0, 0, "R6 reversed");
      run_frame(28'h3C3C3C3, 0, M_NOACK, 0, 0, 0, "R8 no ack off");
      run_frame(28'h6DB6DB6, 0, M_REV,   0, 1, 0, "R8 reversed off");
      run_frame(28'h7777777, 1, M_OK,    0, 0, 0, "R5 bad parity off");
      run_frame(28'h0123456, 1, M_NOACK, 1, 0, 0, "R7 precedence");
      run_frame(28'h1234567, 0, M_OK,    1, 0, 1, "R1 second start");
      run_frame(28'h0000000, 0, M_OK,    1, 0, 0, "R4 zero");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #200us;
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule